// File: doc/BRIEF.md
# Segmented Real-Mode Address Generator

This block turns a 16-bit segment value and a 16-bit offset into a 20-bit physical address. The segment is shifted up by four bit positions and the offset is added to it, which gives a 1 MB space. Distinct segment/offset pairs may land on the same physical byte, and that aliasing is legal. The block holds four segment registers: code, data, stack and extra. A write port loads them. It also keeps a 16-bit stack pointer for a stack that holds only 16-bit words and grows toward lower addresses.

Each request carries an access kind (instruction fetch, data or stack) and a far flag. A near request takes its segment from the register that matches its kind, or from the extra register when it asks for that register explicitly. A far request brings its own segment value. Push and pop commands move the stack pointer by one word and present the stack-top address. Every result appears on a registered address output with a one-cycle valid strobe.

Top module: `rm_addr_gen`

## Requirements
- R1: After a synchronous active-low reset, all four segment registers, the stack pointer, `phys_addr` and `phys_valid` are zero.
- R2: The result is (segment × 16 + offset) truncated to 20 bits, so an address past FFFFFh wraps to the bottom of the space. It appears on `phys_addr`, with `phys_valid` high for exactly one cycle, on the clock edge after the edge that accepts the command.
- R3: A near request picks its segment by `req_kind`: 0 = fetch uses the code register, 1 = data uses the data register, 2 = stack uses the stack register, and 3 is treated as data.
- R4: A far request (`req_far`=1) uses `req_far_seg` in place of any register, whatever `req_kind` and `req_extra` are.
- R5: The extra register is never chosen by default. A near request uses it only when `req_extra`=1, and then it overrides `req_kind`.
- R6: Aliased pairs give equal addresses: A000h:5677h and A111h:4567h both yield A5677h.
- R7: A segment write selects its register with `seg_wr_sel` (0 code, 1 data, 2 stack, 3 extra). A request accepted in the same cycle still sees the old value. Requests from the next cycle on see the new value.
- R8: A push lowers the stack pointer by 2 and outputs stack segment × 16 + the new pointer.
- R9: A pop outputs stack segment × 16 + the current pointer and then raises the pointer by 2.
- R10: The stack pointer wraps modulo 2^16: a push from 0000h gives FFFEh, and a pop from FFFEh gives 0000h.
- R11: Priority in one cycle runs `sp_load` > `stk_push` > `stk_pop` > `req_valid`. The losers are ignored. A load cycle sets `sp_out` to `sp_load_val` and produces no valid address.
- R12: `phys_valid` stays low after a cycle with no push, pop or request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seg_wr_en | input | 1 | Segment register write enable |
| seg_wr_sel | input | 2 | Segment register index (0 code, 1 data, 2 stack, 3 extra) |
| seg_wr_data | input | 16 | Segment value to write |
| req_valid | input | 1 | Address request |
| req_kind | input | 2 | Access kind (0 fetch, 1 data, 2 stack) |
| req_far | input | 1 | Request supplies its own segment |
| req_extra | input | 1 | Near request uses the extra register |
| req_far_seg | input | 16 | Segment supplied by a far request |
| req_offset | input | 16 | Request offset |
| stk_push | input | 1 | Push one word |
| stk_pop | input | 1 | Pop one word |
| sp_load | input | 1 | Load the stack pointer |
| sp_load_val | input | 16 | Value for a stack pointer load |
| phys_addr | output | 20 | Registered physical address |
| phys_valid | output | 1 | One-cycle strobe for `phys_addr` |
| sp_out | output | 16 | Current stack pointer |

## Verification
Near requests of each kind run with four distinct segment values loaded, so a wrong register choice shows up as a wrong high nibble. Far requests are issued with kinds and extra flags that would pick a different register, and the two aliased pairs must give one address. A segment FFFFh with offset FFFFh exposes missing truncation. Push and pop are run across pointer 0000h, and commands are stacked in one cycle to show the priority order. A write and a request in the same cycle tell the old segment value apart from the new one.

// File: rtl/rmag_pkg.sv
// Package: shared encodings for the real-mode address generator.
// Assumes 2-bit kind and segment-index fields on the top ports.
package rmag_pkg;
    typedef enum logic [1:0] {
        KIND_FETCH = 2'd0,
        KIND_DATA  = 2'd1,
        KIND_STACK = 2'd2
    } kind_e;

    typedef enum logic [1:0] {
        SEG_CODE  = 2'd0,
        SEG_DATA  = 2'd1,
        SEG_STACK = 2'd2,
        SEG_EXTRA = 2'd3
    } seg_idx_e;

    localparam int NUM_SEGS = 4;
endpackage

// File: rtl/rmag_seg_regs.sv
// Module: bank of segment registers with a single write port.
// Assumes the index encoding of rmag_pkg. A write is visible on seg_q on
// the following cycle.
module rmag_seg_regs #(
    parameter int SEG_W = 16,
    parameter int NUM   = 4,
    localparam int IDX_W = $clog2(NUM)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [SEG_W-1:0]          wr_data,
    output logic [NUM-1:0][SEG_W-1:0] seg_q
);
    for (genvar g = 0; g < NUM; g++) begin : g_reg
        // Purpose: hold one segment value, clear on reset, load on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                seg_q[g] <= '0;
            else if (wr_en && (wr_idx == IDX_W'(g)))
                seg_q[g] <= wr_data;
        end
    end
endmodule

// File: rtl/rmag_seg_select.sv
// Module: chooses the segment for the current operation.
// Assumes force_stack is high for push/pop. Priority: stack op, far
// segment, explicit extra, then the register implied by the kind.
module rmag_seg_select
    import rmag_pkg::*;
#(
    parameter int SEG_W = 16
) (
    input  logic [NUM_SEGS-1:0][SEG_W-1:0] seg_q,
    input  logic                           force_stack,
    input  logic                           far,
    input  logic [SEG_W-1:0]               far_seg,
    input  logic                           use_extra,
    input  logic [1:0]                     kind,
    output logic [SEG_W-1:0]               seg_out
);
    // Purpose: priority mux of the segment source.
    always_comb begin
        if (force_stack)
            seg_out = seg_q[SEG_STACK];
        else if (far)
            seg_out = far_seg;
        else if (use_extra)
            seg_out = seg_q[SEG_EXTRA];
        else begin
            case (kind)
                KIND_FETCH: seg_out = seg_q[SEG_CODE];
                KIND_STACK: seg_out = seg_q[SEG_STACK];
                default:    seg_out = seg_q[SEG_DATA];
            endcase
        end
    end
endmodule

// File: rtl/rmag_phys_adder.sv
// Module: shifted-segment plus offset adder.
// Assumes ADDR_W <= the full sum width. Carries above ADDR_W are dropped,
// which wraps the space.
module rmag_phys_adder #(
    parameter int SEG_W  = 16,
    parameter int OFF_W  = 16,
    parameter int SHIFT  = 4,
    parameter int ADDR_W = SEG_W + SHIFT,
    localparam int SUM_W = ((SEG_W + SHIFT) > OFF_W ? (SEG_W + SHIFT) : OFF_W) + 1
) (
    input  logic [SEG_W-1:0]  seg,
    input  logic [OFF_W-1:0]  off,
    output logic [ADDR_W-1:0] phys
);
    logic [SUM_W-1:0] sum;

    // Purpose: full-width sum, then truncate to the address width.
    always_comb begin
        sum  = (SUM_W'(seg) << SHIFT) + SUM_W'(off);
        phys = sum[ADDR_W-1:0];
    end
endmodule

// File: rtl/rmag_stack_ptr.sv
// Module: word stack pointer with pre-decrement push and post-increment pop.
// Assumes the caller has already resolved priority so that at most one of
// load/push/pop is high. The pointer wraps modulo 2^OFF_W.
module rmag_stack_ptr #(
    parameter int OFF_W      = 16,
    parameter int WORD_BYTES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [OFF_W-1:0] load_val,
    input  logic             push,
    input  logic             pop,
    output logic [OFF_W-1:0] sp_q,
    output logic [OFF_W-1:0] stack_off
);
    localparam logic [OFF_W-1:0] STEP = OFF_W'(WORD_BYTES);

    // Purpose: offset presented for a stack access (new pointer for push, current for pop).
    always_comb begin
        stack_off = push ? (sp_q - STEP) : sp_q;
    end

    // Purpose: update the pointer for a load, push or pop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sp_q <= '0;
        else if (load)
            sp_q <= load_val;
        else if (push)
            sp_q <= sp_q - STEP;
        else if (pop)
            sp_q <= sp_q + STEP;
    end

    assert_push_dec_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !load) |=> sp_q == $past(sp_q) - STEP);
    assert_pop_inc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !load) |=> sp_q == $past(sp_q) + STEP);
    assert_sp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!pop && !push && !load) |=> $stable(sp_q));
endmodule

// File: rtl/rm_addr_gen.sv
// Module: top of the segmented real-mode address generator.
// Resolves command priority (load > push > pop > request), selects a
// segment, forms the physical address and registers it with a one-cycle
// valid strobe. The address output holds its value between strobes.
module rm_addr_gen
    import rmag_pkg::*;
#(
    parameter int SEG_W      = 16,
    parameter int OFF_W      = 16,
    parameter int SHIFT      = 4,
    parameter int WORD_BYTES = 2,
    localparam int ADDR_W    = SEG_W + SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seg_wr_en,
    input  logic [1:0]        seg_wr_sel,
    input  logic [SEG_W-1:0]  seg_wr_data,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic              req_far,
    input  logic              req_extra,
    input  logic [SEG_W-1:0]  req_far_seg,
    input  logic [OFF_W-1:0]  req_offset,
    input  logic              stk_push,
    input  logic              stk_pop,
    input  logic              sp_load,
    input  logic [OFF_W-1:0]  sp_load_val,
    output logic [ADDR_W-1:0] phys_addr,
    output logic              phys_valid,
    output logic [OFF_W-1:0]  sp_out
);
    logic                           do_push, do_pop, do_req, do_stack;
    logic [NUM_SEGS-1:0][SEG_W-1:0] seg_q;
    logic [SEG_W-1:0]               sel_seg;
    logic [OFF_W-1:0]               stack_off, sel_off;
    logic [ADDR_W-1:0]              phys_next;

    // Purpose: one winner per cycle in the fixed priority order.
    always_comb begin
        do_push  = !sp_load && stk_push;
        do_pop   = !sp_load && !stk_push && stk_pop;
        do_req   = !sp_load && !stk_push && !stk_pop && req_valid;
        do_stack = do_push || do_pop;
        sel_off  = do_stack ? stack_off : req_offset;
    end

    rmag_seg_regs #(.SEG_W(SEG_W), .NUM(NUM_SEGS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (seg_wr_en),
        .wr_idx  (seg_wr_sel),
        .wr_data (seg_wr_data),
        .seg_q   (seg_q)
    );

    rmag_stack_ptr #(.OFF_W(OFF_W), .WORD_BYTES(WORD_BYTES)) u_sp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (sp_load),
        .load_val  (sp_load_val),
        .push      (do_push),
        .pop       (do_pop),
        .sp_q      (sp_out),
        .stack_off (stack_off)
    );

    rmag_seg_select #(.SEG_W(SEG_W)) u_sel (
        .seg_q       (seg_q),
        .force_stack (do_stack),
        .far         (req_far),
        .far_seg     (req_far_seg),
        .use_extra   (req_extra),
        .kind        (req_kind),
        .seg_out     (sel_seg)
    );

    rmag_phys_adder #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W)) u_add (
        .seg  (sel_seg),
        .off  (sel_off),
        .phys (phys_next)
    );

    // Purpose: register the address and raise the strobe for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phys_addr  <= '0;
            phys_valid <= 1'b0;
        end else begin
            phys_valid <= do_stack || do_req;
            if (do_stack || do_req)
                phys_addr <= phys_next;
        end
    end

    assert_cmd_gives_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sp_load && (stk_push || stk_pop || req_valid)) |=> phys_valid);
    assert_idle_no_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!stk_push && !stk_pop && !req_valid) |=> !phys_valid);
    assert_load_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sp_load |=> (!phys_valid && sp_out == $past(sp_load_val)));
    assert_far_seg_used_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sp_load && !stk_push && !stk_pop && req_valid && req_far) |=>
        phys_addr == ADDR_W'({$past(req_far_seg), {SHIFT{1'b0}}}) + ADDR_W'($past(req_offset)));
endmodule

// File: tb/rm_addr_gen_bench.sv
module rm_addr_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        seg_wr_en;
    logic [1:0]  seg_wr_sel;
    logic [15:0] seg_wr_data;
    logic        req_valid;
    logic [1:0]  req_kind;
    logic        req_far, req_extra;
    logic [15:0] req_far_seg, req_offset;
    logic        stk_push, stk_pop, sp_load;
    logic [15:0] sp_load_val;
    logic [19:0] phys_addr;
    logic        phys_valid;
    logic [15:0] sp_out;

    int checks = 0;
    int failures = 0;

    typedef struct {
        string       tag;
        logic        v;
        logic [19:0] a;
        logic [15:0] sp;
    } exp_t;
    exp_t q[$];

    logic [15:0] m_seg [4];
    logic [15:0] m_sp;

    always #10 clk = ~clk;

    rm_addr_gen u_rm_addr_gen (
        .clk(clk), .rst_n(rst_n),
        .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel), .seg_wr_data(seg_wr_data),
        .req_valid(req_valid), .req_kind(req_kind), .req_far(req_far),
        .req_extra(req_extra), .req_far_seg(req_far_seg), .req_offset(req_offset),
        .stk_push(stk_push), .stk_pop(stk_pop), .sp_load(sp_load),
        .sp_load_val(sp_load_val),
        .phys_addr(phys_addr), .phys_valid(phys_valid), .sp_out(sp_out)
    );

    function automatic logic [19:0] lin(input logic [15:0] s, input logic [15:0] o);
        return {s, 4'h0} + {4'h0, o};
    endfunction

    task automatic chk(input string tag, input string what, input logic [19:0] act, input logic [19:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus and queue the expected result.
    task automatic drive(input logic wen, input logic [1:0] wsel, input logic [15:0] wdat,
                         input logic rq, input logic [1:0] kind, input logic far,
                         input logic ext, input logic [15:0] fseg, input logic [15:0] off,
                         input logic push, input logic pop, input logic ld,
                         input logic [15:0] ldv, input string tag);
        exp_t e;
        logic [15:0] s;
        @(negedge clk);
        seg_wr_en = wen; seg_wr_sel = wsel; seg_wr_data = wdat;
        req_valid = rq; req_kind = kind; req_far = far; req_extra = ext;
        req_far_seg = fseg; req_offset = off;
        stk_push = push; stk_pop = pop; sp_load = ld; sp_load_val = ldv;
        e.tag = tag; e.v = 1'b0; e.a = '0;
        if (ld) begin
            m_sp = ldv;
        end else if (push) begin
            m_sp = m_sp - 16'd2;
            e.v = 1'b1; e.a = lin(m_seg[2], m_sp);
        end else if (pop) begin
            e.v = 1'b1; e.a = lin(m_seg[2], m_sp);
            m_sp = m_sp + 16'd2;
        end else if (rq) begin
            if (far) s = fseg;
            else if (ext) s = m_seg[3];
            else if (kind == 2'd0) s = m_seg[0];
            else if (kind == 2'd2) s = m_seg[2];
            else s = m_seg[1];
            e.v = 1'b1; e.a = lin(s, off);
        end
        if (wen) m_seg[wsel] = wdat;
        e.sp = m_sp;
        q.push_back(e);
    endtask

    task automatic idle(input string tag);
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic segw(input logic [1:0] sel, input logic [15:0] v);
        drive(1, sel, v, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
    endtask
    task automatic near(input logic [1:0] kind, input logic [15:0] off, input string tag);
        drive(0, 0, 0, 1, kind, 0, 0, 0, off, 0, 0, 0, 0, tag);
    endtask

    // Monitor: between edges, pop the expected item for the last edge and compare.
    always begin
        @(posedge clk);
        #5;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(e.tag, "phys_valid", 20'(phys_valid), 20'(e.v));
            if (e.v) chk(e.tag, "phys_addr", phys_addr, e.a);
            chk(e.tag, "sp_out", 20'(sp_out), 20'(e.sp));
        end
    end

    initial begin
        #4_000_000;
        failures++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) m_seg[i] = '0;
        m_sp = '0;
        rst_n = 1'b0;
        seg_wr_en = 0; seg_wr_sel = 0; seg_wr_data = 0; req_valid = 0; req_kind = 0;
        req_far = 0; req_extra = 0; req_far_seg = 0; req_offset = 0;
        stk_push = 0; stk_pop = 0; sp_load = 0; sp_load_val = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R7 loads, then R3 default selection per kind
        segw(2'd0, 16'h1000); segw(2'd1, 16'hA000);
        segw(2'd2, 16'h2000); segw(2'd3, 16'h3000);
        near(2'd0, 16'h0010, "R3");
        near(2'd1, 16'h5677, "R6");
        near(2'd2, 16'h0100, "R3");
        near(2'd3, 16'h0200, "R3");
        // R4 far overrides kind and extra; R6 aliasing
        drive(0, 0, 0, 1, 2'd1, 1, 0, 16'hA111, 16'h4567, 0, 0, 0, 0, "R6");
        drive(0, 0, 0, 1, 2'd0, 1, 1, 16'h4000, 16'h0001, 0, 0, 0, 0, "R4");
        // R5 extra only on explicit select
        drive(0, 0, 0, 1, 2'd1, 0, 1, 0, 16'h0020, 0, 0, 0, 0, "R5");
        drive(0, 0, 0, 1, 2'd2, 0, 1, 0, 16'h0020, 0, 0, 0, 0, "R5");
        // R7 same-cycle write sees old value, then new; R2 wrap at 1 MB
        drive(1, 2'd1, 16'hFFFF, 1, 2'd1, 0, 0, 0, 16'h0000, 0, 0, 0, 0, "R7");
        near(2'd1, 16'hFFFF, "R2");
        // R11 load gives no strobe; R8/R10 push across zero; R9 pops
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 16'h0000, "R11");
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R10");
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R8");
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R9");
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R10");
        // R11 priority combinations
        drive(0, 0, 0, 1, 2'd1, 0, 0, 0, 16'h0044, 1, 1, 0, 0, "R11");
        drive(0, 0, 0, 1, 2'd1, 0, 0, 0, 16'h0044, 1, 0, 1, 16'h1234, "R11");
        drive(0, 0, 0, 1, 2'd1, 0, 0, 0, 16'h0044, 0, 1, 0, 0, "R11");
        idle("R12");
        idle("R12");
        @(negedge clk);

        // R1: reset clears everything
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1", "phys_valid", 20'(phys_valid), 20'd0);
        chk("R1", "phys_addr", phys_addr, 20'd0);
        chk("R1", "sp_out", 20'(sp_out), 20'd0);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) m_seg[i] = '0;
        m_sp = '0;
        near(2'd0, 16'h1234, "R1");
        near(2'd1, 16'h0042, "R1");
        idle("R12");
        @(negedge clk);
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule